// File: doc/BRIEF.md
# Hashed Page Table Entry Placement Engine

This block is a sequential engine that places new address translations into a hashed page table held in ordinary memory. For each 4 KB page it receives a segment identifier, an effective address and a set of cache attribute bits. From these it forms the two words of a table entry and a 19-bit hash. The hash and the table origin and mask select a 64-byte group of eight entry slots. The engine then reads slots over a single-word memory port until it finds a place for the entry. It writes the entry upper word first and then the lower word.

The search first looks for the first empty slot in the primary group and then in the secondary group. When both groups are full, the engine either reports an error or, if replacement is allowed, evicts an entry. A victim whose changed bit is clear is taken first. If no such entry exists, the last slot is overwritten and the evicted real page number is reported so that software can write it back. Two further commands are provided. One zeroes the whole table one word at a time. The other inserts every page of an address range and stops at the first page that fails.

Top module: `pte_place_engine`

## Requirements
- R1: The upper word written for an entry is {valid=1 in bit 31, segment id in bits 30:7, group-select flag in bit 6, effective address bits 27:22 in bits 5:0}.
- R2: The lower word written is {effective address bits 31:12 in bits 31:12, zeros in 11:9, referenced=1 in bit 8, changed=1 in bit 7, attribute bits in 6:3, 0 in bit 2, protection code 2'b10 in bits 1:0}.
- R3: The primary hash is seg[18:0] XOR {3'b000, ea[27:12]}, and the secondary hash is its bitwise inverse. The group address is {org[15:9], org[8:0] | (mask & hash[18:10]), hash[9:0], 6'b0}, and slot k has its upper word at group + 8k and its lower word at group + 8k + 4.
- R4: An entry goes into the lowest-numbered primary slot whose upper word has bit 31 clear. The result is code 0 (inserted), and slot_addr gives the address of the slot's upper word.
- R5: If all eight primary slots are valid, the first free secondary slot is used, and the group-select flag (bit 6 of the upper word) is set to 1.
- R6: If all sixteen slots are valid and replacement is not allowed, the result is code 3 (error) and no memory write takes place.
- R7: If all sixteen slots are valid and replacement is allowed, the first slot in the order primary 0..7 and then secondary 0..7 whose lower word has the changed bit (bit 7) clear is overwritten. The result is code 1.
- R8: If all sixteen slots also have the changed bit set, secondary slot 7 is overwritten. The result is code 2, and flush_rpn carries bits 31:12 of that slot's old lower word.
- R9: Command 0 writes zero to every word from {org,16'h0000} for ((mask+1) << 14) words, at ascending consecutive addresses, and performs no other write.
- R10: The upper word is written in the cycle directly before the lower word of the same slot.
- R11: Command 2 inserts each 4 KB page from the page of ea_start up to, but not including, ea_end. It stops after the first page whose result is an error. Command 1 inserts a single page.
- R12: A start is accepted only while idle. done is a single-cycle pulse, and the results stay stable until the next start. Every memory access is word aligned, and no access happens while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a command (sampled while idle) |
| cmd | input | 2 | 0 clear table, 1 insert one page, 2 insert a page range |
| allow_replace | input | 1 | Permit eviction when both groups are full |
| ea_start | input | 32 | Effective address of the (first) page |
| ea_end | input | 32 | Exclusive end address for range mode |
| vsid | input | 24 | Segment identifier for the entry |
| wimg | input | 4 | Cache attribute bits stored in the lower word |
| tbl_org | input | 16 | Table origin, address bits 31:16 |
| tbl_mask | input | 9 | Table size mask |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 inserted, 1 replaced clean, 2 replaced needs flush, 3 error |
| slot_addr | output | 32 | Upper-word address of the last slot written |
| flush_rpn | output | 20 | Real page number of the evicted dirty entry |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
Read data arrives one cycle after a read request, so checking a slot takes two cycles. A clean-victim scan goes through all sixteen upper words before it touches any lower words. done therefore follows a variable number of cycles after start: 2 per slot examined, plus 2 writes, plus 2 cycles of wrap-up for each page. A clear lasts exactly one cycle per word. The bench does not predict these cycle counts. Instead, at each falling edge it waits for the done pulse and samples result, slot_addr and flush_rpn in that cycle. It then compares the memory contents and the number of writes against a bench model that runs the same placement policy on a shadow table.

// File: rtl/pte_place_pkg.sv
`timescale 1ns/1ps
// Shared constants, command/result codes and controller states for the
// page table placement engine. Assumes 32-bit byte addresses, 4 KB pages.
package pte_place_pkg;
    localparam int AW      = 32;
    localparam int PAGE_SH = 12;
    localparam int RPN_W   = AW - PAGE_SH;
    localparam int VSID_W  = 24;
    localparam int HASH_W  = 19;
    localparam int API_W   = 6;
    localparam int WIMG_W  = 4;
    localparam int ORG_W   = 16;
    localparam int MASK_W  = 9;
    localparam int SLOT_W  = 3;
    localparam int GRP_SH  = 6;
    localparam int LOW_W   = HASH_W - MASK_W;
    localparam int CNT_W   = MASK_W + 1 + (AW - ORG_W - 2);

    typedef enum logic [1:0] {CMD_CLEAR, CMD_ONE, CMD_RANGE, CMD_SPARE} cmd_e;
    typedef enum logic [1:0] {RES_NEW, RES_CLEAN, RES_DIRTY, RES_ERR} res_e;
    typedef enum logic [3:0] {
        ST_IDLE, ST_CLR, ST_RD, ST_CHK, ST_WUP, ST_WLO, ST_NEXT, ST_DONE
    } st_e;
endpackage

// File: rtl/pte_word_build.sv
`timescale 1ns/1ps
// Builds the upper and lower entry words and the selected hash for one page.
// Assumes an identity mapping (real page = effective page).
module pte_word_build
    import pte_place_pkg::*;
(
    input  logic [RPN_W-1:0]  page,
    input  logic [VSID_W-1:0] seg,
    input  logic [WIMG_W-1:0] attr,
    input  logic              sec,
    output logic [AW-1:0]     upper,
    output logic [AW-1:0]     lower,
    output logic [HASH_W-1:0] hash
);
    localparam int IDX_W = 16;
    logic [HASH_W-1:0] prim;

    // Primary hash from the segment id and page index; the secondary hash is the inverse.
    always_comb begin
        prim = seg[HASH_W-1:0] ^ {{(HASH_W-IDX_W){1'b0}}, page[IDX_W-1:0]};
        hash = sec ? ~prim : prim;
    end

    // Entry word formats: valid/segment/select/api and page/R/C/attr/protection.
    always_comb begin
        upper = {1'b1, seg, sec, page[IDX_W-1:IDX_W-API_W]};
        lower = {page, 3'b000, 1'b1, 1'b1, attr, 1'b0, 2'b10};
    end
endmodule

// File: rtl/pte_group_addr.sv
`timescale 1ns/1ps
// Forms the 64-byte group address from the table origin, size mask and hash.
// Assumes the origin has zeros wherever the mask has ones.
module pte_group_addr
    import pte_place_pkg::*;
(
    input  logic [HASH_W-1:0] hash,
    input  logic [ORG_W-1:0]  org,
    input  logic [MASK_W-1:0] mask,
    output logic [AW-1:0]     grp
);
    // The upper hash bits are ORed into the origin under the mask; the low hash bits pick the group.
    always_comb begin
        grp = {org[ORG_W-1:MASK_W],
               org[MASK_W-1:0] | (mask & hash[HASH_W-1:LOW_W]),
               hash[LOW_W-1:0],
               {GRP_SH{1'b0}}};
    end
endmodule

// File: rtl/pte_place_engine.sv
`timescale 1ns/1ps
// Page table placement engine: clears the table, or inserts one page or a range
// of pages with a first-free search over the primary and then the secondary group,
// plus optional clean-first eviction. The memory port returns read data one cycle after the request.
module pte_place_engine
    import pte_place_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         cmd,
    input  logic               allow_replace,
    input  logic [AW-1:0]      ea_start,
    input  logic [AW-1:0]      ea_end,
    input  logic [VSID_W-1:0]  vsid,
    input  logic [WIMG_W-1:0]  wimg,
    input  logic [ORG_W-1:0]   tbl_org,
    input  logic [MASK_W-1:0]  tbl_mask,
    output logic               busy,
    output logic               done,
    output logic [1:0]         result,
    output logic [AW-1:0]      slot_addr,
    output logic [RPN_W-1:0]   flush_rpn,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [AW-1:0]      mem_wdata,
    input  logic [AW-1:0]      mem_rdata
);
    localparam logic [AW-1:0] PAGE_BYTES = AW'(1) << PAGE_SH;
    localparam logic [AW-1:0] VALID_BIT  = AW'(1) << (AW-1);
    localparam logic [AW-1:0] CHG_BIT    = AW'(1) << 7;
    localparam int            WPT_SH     = AW - ORG_W - 2;

    st_e               state_q;
    logic [AW-1:0]     ea_q, end_q;
    logic [VSID_W-1:0] seg_q;
    logic [WIMG_W-1:0] attr_q;
    logic [ORG_W-1:0]  org_q;
    logic [MASK_W-1:0] mask_q;
    logic              repl_q, range_q, sec_q, cscan_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CNT_W-1:0]  cnt_q;
    res_e              res_q;
    logic [AW-1:0]     slot_addr_q;
    logic [RPN_W-1:0]  rpn_q;

    logic [AW-1:0]     upper_w, lower_w, grp_w, up_addr;
    logic [HASH_W-1:0] hash_w;
    logic [CNT_W-1:0]  clr_last;
    logic [AW-1:0]     nxt_ea;
    logic              hit, last_slot;

    pte_word_build u_build (
        .page (ea_q[AW-1:PAGE_SH]), .seg(seg_q), .attr(attr_q), .sec(sec_q),
        .upper(upper_w), .lower(lower_w), .hash(hash_w)
    );

    pte_group_addr u_grp (
        .hash(hash_w), .org(org_q), .mask(mask_q), .grp(grp_w)
    );

    // Slot address, clear length and the free/clean test on the returned word.
    always_comb begin
        up_addr   = grp_w | {{(AW-SLOT_W-3){1'b0}}, slot_q, 3'b000};
        clr_last  = ({1'b0, mask_q} + CNT_W'(1)) << WPT_SH;
        clr_last  = clr_last - CNT_W'(1);
        nxt_ea    = ea_q + PAGE_BYTES;
        hit       = cscan_q ? ((mem_rdata & CHG_BIT) == '0) : ((mem_rdata & VALID_BIT) == '0);
        last_slot = sec_q && (slot_q == '1);
    end

    // Memory port drive for each controller state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = up_addr;
        mem_wdata = '0;
        case (state_q)
            ST_CLR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {org_q, {(AW-ORG_W){1'b0}}} + {{(AW-CNT_W-2){1'b0}}, cnt_q, 2'b00};
            end
            ST_RD:  begin
                mem_req  = 1'b1;
                mem_addr = up_addr | {{(AW-3){1'b0}}, cscan_q, 2'b00};
            end
            ST_WUP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = upper_w;
            end
            ST_WLO: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = up_addr | AW'(4);
                mem_wdata = lower_w;
            end
            default: ;
        endcase
    end

    // Controller: command decode, slot scan, victim choice, page stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; ea_q <= '0; end_q <= '0; seg_q <= '0; attr_q <= '0;
            org_q <= '0; mask_q <= '0; repl_q <= 1'b0; range_q <= 1'b0;
            sec_q <= 1'b0; cscan_q <= 1'b0; slot_q <= '0; cnt_q <= '0;
            res_q <= RES_NEW; slot_addr_q <= '0; rpn_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    ea_q    <= ea_start & ~(PAGE_BYTES - AW'(1));
                    end_q   <= ea_end;
                    seg_q   <= vsid;      attr_q <= wimg;
                    org_q   <= tbl_org;   mask_q <= tbl_mask;
                    repl_q  <= allow_replace;
                    range_q <= (cmd == CMD_RANGE);
                    sec_q <= 1'b0; cscan_q <= 1'b0; slot_q <= '0; cnt_q <= '0;
                    res_q <= RES_NEW; slot_addr_q <= '0; rpn_q <= '0;
                    if (cmd == CMD_CLEAR)
                        state_q <= ST_CLR;
                    else if (cmd == CMD_RANGE && (ea_start & ~(PAGE_BYTES - AW'(1))) >= ea_end)
                        state_q <= ST_DONE;
                    else
                        state_q <= ST_RD;
                end
                ST_CLR: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cnt_q == clr_last) state_q <= ST_DONE;
                end
                ST_RD: state_q <= ST_CHK;
                ST_CHK: begin
                    if (hit) begin
                        res_q   <= cscan_q ? RES_CLEAN : RES_NEW;
                        state_q <= ST_WUP;
                    end else if (last_slot) begin
                        if (cscan_q) begin
                            res_q   <= RES_DIRTY;
                            rpn_q   <= mem_rdata[AW-1:PAGE_SH];
                            state_q <= ST_WUP;
                        end else if (repl_q) begin
                            cscan_q <= 1'b1; sec_q <= 1'b0; slot_q <= '0;
                            state_q <= ST_RD;
                        end else begin
                            res_q   <= RES_ERR;
                            state_q <= ST_NEXT;
                        end
                    end else begin
                        slot_q <= slot_q + SLOT_W'(1);
                        if (slot_q == '1) sec_q <= 1'b1;
                        state_q <= ST_RD;
                    end
                end
                ST_WUP: begin
                    slot_addr_q <= up_addr;
                    state_q     <= ST_WLO;
                end
                ST_WLO: state_q <= ST_NEXT;
                ST_NEXT: begin
                    if (range_q && res_q != RES_ERR && nxt_ea < end_q) begin
                        ea_q <= nxt_ea;
                        sec_q <= 1'b0; cscan_q <= 1'b0; slot_q <= '0;
                        state_q <= ST_RD;
                    end else begin
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done      = (state_q == ST_DONE);
    assign result    = res_q;
    assign slot_addr = slot_addr_q;
    assign flush_rpn = rpn_q;

    // Upper word is followed at once by the lower word of the same slot (R10).
    assert_up_then_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WUP) |=> (mem_we && mem_addr == $past(mem_addr) + 32'd4));

    // Clear writes walk consecutive words (R9).
    assert_clear_stride_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLR && $past(state_q) == ST_CLR) |-> (mem_we && mem_addr == $past(mem_addr) + 32'd4));

    // done lasts one cycle and results hold until a new start (R12).
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done || !busy) && !start |=> ($stable(result) && $stable(slot_addr)));

    // No access while idle, all accesses aligned (R12).
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
    assert_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // Dirty eviction only when replacement was allowed (R8).
    assert_dirty_needs_repl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 2'd2) |-> repl_q);
endmodule

// File: tb/pte_place_engine_tb.sv
`timescale 1ns/1ps
module pte_place_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic        allow_replace = 1'b0;
    logic [31:0] ea_start = '0, ea_end = '0;
    logic [23:0] vsid = '0;
    logic [3:0]  wimg = '0;
    logic [15:0] tbl_org = 16'h0010;
    logic [8:0]  tbl_mask = '0;
    logic        busy, done, mem_req, mem_we;
    logic [1:0]  result;
    logic [31:0] slot_addr, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [19:0] flush_rpn;

    always #2.5 clk = ~clk;

    pte_place_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .allow_replace(allow_replace),
        .ea_start(ea_start), .ea_end(ea_end), .vsid(vsid), .wimg(wimg),
        .tbl_org(tbl_org), .tbl_mask(tbl_mask), .busy(busy), .done(done),
        .result(result), .slot_addr(slot_addr), .flush_rpn(flush_rpn),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [31:0] mem     [int unsigned];
    logic [31:0] ref_mem [int unsigned];
    int total = 0, bad = 0, wr_cnt = 0, cyc = 0;
    bit finished = 0;

    // Memory model: read data one cycle after the request.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr] = mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            end
        end
    end

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction
    function automatic logic [31:0] rd_ref(input logic [31:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [18:0] b_hash(input logic [23:0] v, input logic [31:0] ea, input bit sec);
        logic [18:0] h = v[18:0] ^ {3'b000, ea[27:12]};
        return sec ? ~h : h;
    endfunction
    function automatic logic [31:0] b_grp(input logic [18:0] h);
        return {tbl_org[15:9], tbl_org[8:0] | (tbl_mask & h[18:10]), h[9:0], 6'b0};
    endfunction
    function automatic logic [31:0] b_up(input logic [23:0] v, input logic [31:0] ea, input bit sec);
        return {1'b1, v, sec, ea[27:22]};
    endfunction
    function automatic logic [31:0] b_lo(input logic [31:0] ea, input logic [3:0] w);
        return {ea[31:12], 3'b000, 2'b11, w, 1'b0, 2'b10};
    endfunction

    // Bench model of one page placement on the shadow table.
    task automatic ref_page(input logic [31:0] ea, input logic [23:0] v, input logic [3:0] w,
                            input bit repl, output logic [1:0] res, output logic [31:0] sa,
                            output logic [19:0] rpn, inout int nwr);
        bit found = 0;
        bit fsec = 0;
        res = 2'd3; sa = 32'h0;
        for (int s = 0; s < 16 && !found; s++) begin
            logic [31:0] a = b_grp(b_hash(v, ea, s >= 8)) + 32'((s % 8) * 8);
            if (!rd_ref(a)[31]) begin found = 1; sa = a; fsec = (s >= 8); res = 2'd0; end
        end
        if (!found && repl) begin
            for (int s = 0; s < 16 && !found; s++) begin
                logic [31:0] a = b_grp(b_hash(v, ea, s >= 8)) + 32'((s % 8) * 8);
                if (!rd_ref(a + 4)[7]) begin found = 1; sa = a; fsec = (s >= 8); res = 2'd1; end
            end
            if (!found) begin
                sa = b_grp(b_hash(v, ea, 1'b1)) + 32'd56;
                rpn = rd_ref(sa + 4)[31:12];
                fsec = 1; found = 1; res = 2'd2;
            end
        end
        if (found) begin
            ref_mem[sa]     = b_up(v, ea, fsec);
            ref_mem[sa + 4] = b_lo(ea, w);
            nwr += 2;
        end
    endtask

    // Run one insertion command on the DUT and compare against the model.
    task automatic run_op(input logic [1:0] c, input logic [31:0] ea, input logic [31:0] ee,
                          input logic [23:0] v, input logic [3:0] w, input bit repl, input string req);
        logic [1:0]  e_res = 2'd0;
        logic [31:0] e_sa = 32'h0;
        logic [19:0] e_rpn = 20'h0;
        int e_wr = 0;
        int w0;
        int t = 0;
        logic [31:0] pg = {ea[31:12], 12'h000};
        if (c == 2'd1) ref_page(pg, v, w, repl, e_res, e_sa, e_rpn, e_wr);
        else begin
            while (pg < ee) begin
                ref_page(pg, v, w, repl, e_res, e_sa, e_rpn, e_wr);
                if (e_res == 2'd3) break;
                pg = pg + 32'h1000;
            end
        end
        @(negedge clk);
        w0 = wr_cnt;
        cmd = c; ea_start = ea; ea_end = ee; vsid = v; wimg = w; allow_replace = repl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && t < 40000) begin @(negedge clk); t++; end
        chk(done, {req, " watchdog"}, 32'(t), 32'd0);
        chk(result == e_res, {req, " result"}, 32'(result), 32'(e_res));
        chk(wr_cnt - w0 == e_wr, {req, " write count"}, 32'(wr_cnt - w0), 32'(e_wr));
        if (e_res != 2'd3 && e_wr > 0) begin
            chk(slot_addr == e_sa, {req, " slot address"}, slot_addr, e_sa);
            chk(rd_mem(e_sa) == rd_ref(e_sa), {req, " R1 upper word"}, rd_mem(e_sa), rd_ref(e_sa));
            chk(rd_mem(e_sa + 4) == rd_ref(e_sa + 4), {req, " R2 lower word"}, rd_mem(e_sa + 4), rd_ref(e_sa + 4));
        end
        if (e_res == 2'd2)
            chk(flush_rpn == e_rpn, {req, " R8 flush rpn"}, 32'(flush_rpn), 32'(e_rpn));
    endtask

    task automatic do_clear();
        int w0;
        int t = 0;
        @(negedge clk);
        w0 = wr_cnt;
        cmd = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && t < 40000) begin @(negedge clk); t++; end
        ref_mem.delete();
        chk(done, "R9 clear watchdog", 32'(t), 32'd0);
        chk(wr_cnt - w0 == ((int'(tbl_mask) + 1) << 14), "R9 clear write count",
            32'(wr_cnt - w0), 32'((int'(tbl_mask) + 1) << 14));
    endtask

    // Fill the primary and secondary groups of hash h with n entries.
    task automatic fill(input logic [18:0] h, input int n, input logic [31:0] base, input string req);
        for (int k = 0; k < n; k++) begin
            logic [31:0] ea = base + 32'(k << 12);
            logic [23:0] v = {5'(k + 1), h ^ {3'b000, ea[27:12]}};
            run_op(2'd1, ea, 32'h0, v, 4'(k), 1'b0, req);
            if (k < 8) chk(slot_addr == b_grp(h) + 32'(k * 8), "R4 first free primary slot",
                           slot_addr, b_grp(h) + 32'(k * 8));
            else begin
                chk(slot_addr == b_grp(~h) + 32'((k - 8) * 8), "R5 secondary slot",
                    slot_addr, b_grp(~h) + 32'((k - 8) * 8));
                chk(rd_mem(slot_addr)[6] == 1'b1, "R5 select flag", 32'(rd_mem(slot_addr)[6]), 32'd1);
            end
        end
    endtask

    // Global watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            bad++; total++;
            $display("FAIL R12 global watchdog actual=%0d expected=<190000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [18:0] hA, hR;
        logic [31:0] a;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R12 reset idle", {29'b0, busy, done, mem_req}, 32'd0);
        chk(result == 2'd0, "R12 reset result", 32'(result), 32'd0);

        // R9: clear zeroes stale words.
        mem[32'h0010_0100] = 32'hFFFF_FFFF;
        mem[32'h0010_FFFC] = 32'h8000_0001;
        do_clear();
        chk(rd_mem(32'h0010_0100) == 0, "R9 word zeroed", rd_mem(32'h0010_0100), 0);
        chk(rd_mem(32'h0010_FFFC) == 0, "R9 last word zeroed", rd_mem(32'h0010_FFFC), 0);
        chk(mem.exists(32'h0010_0000) && !mem.exists(32'h0011_0000), "R9 clear extent", 32'(mem.num()), 32'd16384);

        // R3: masked origin with upper hash bits.
        tbl_org = 16'h0200; tbl_mask = 9'h003;
        run_op(2'd1, 32'h0000_0000, 32'h0, 24'h000C05, 4'h5, 1'b0, "R3 masked group");
        a = {16'h0200 | 16'h0003, 10'h005, 6'b0};
        chk(slot_addr == a, "R3 group address", slot_addr, a);
        tbl_org = 16'h0010; tbl_mask = 9'h000;

        // R4/R5/R6/R8/R7 directed on one hash.
        hA = 19'h1_2345;
        fill(hA, 16, 32'h4000_0000, "R4 R5 fill");
        run_op(2'd1, 32'h5000_0000, 32'h0, {5'h1F, hA ^ {3'b000, 16'h0000}}, 4'h3, 1'b0, "R6 full no replace");
        run_op(2'd1, 32'h5000_0000, 32'h0, {5'h1F, hA ^ {3'b000, 16'h0000}}, 4'h3, 1'b1, "R8 all dirty");
        chk(slot_addr == b_grp(~hA) + 32'd56, "R8 last slot", slot_addr, b_grp(~hA) + 32'd56);
        a = b_grp(hA) + 32'd40 + 32'd4;   mem[a][7] = 1'b0; ref_mem[a][7] = 1'b0;
        a = b_grp(~hA) + 32'd16 + 32'd4;  mem[a][7] = 1'b0; ref_mem[a][7] = 1'b0;
        run_op(2'd1, 32'h5100_0000, 32'h0, {5'h1E, hA ^ {3'b000, 16'h1000}}, 4'h1, 1'b1, "R7 clean primary");
        chk(slot_addr == b_grp(hA) + 32'd40, "R7 primary victim first", slot_addr, b_grp(hA) + 32'd40);
        run_op(2'd1, 32'h5200_0000, 32'h0, {5'h1D, hA ^ {3'b000, 16'h2000}}, 4'h2, 1'b1, "R7 clean secondary");
        chk(slot_addr == b_grp(~hA) + 32'd16, "R7 secondary victim", slot_addr, b_grp(~hA) + 32'd16);
        chk(rd_mem(slot_addr)[6] == 1'b1, "R7 select flag on victim", 32'(rd_mem(slot_addr)[6]), 32'd1);

        // R11: range stops at first error.
        do_clear();
        a = 32'h0123_4000;
        hR = b_hash(24'h0ABCDE, a + 32'h2000, 1'b0);
        fill(hR, 16, 32'h6000_0000, "R11 prefill");
        run_op(2'd2, a, a + 32'h5000, 24'h0ABCDE, 4'h6, 1'b0, "R11 range error stop");
        chk(rd_mem(b_grp(b_hash(24'h0ABCDE, a + 32'h3000, 1'b0)))[31] == 1'b0, "R11 page after error untouched",
            rd_mem(b_grp(b_hash(24'h0ABCDE, a + 32'h3000, 1'b0))), 32'h0);
        run_op(2'd2, 32'h0777_0000, 32'h0777_4000, 24'h012345, 4'h9, 1'b0, "R11 range full");
        run_op(2'd2, 32'h0777_0000, 32'h0777_0000, 24'h012345, 4'h9, 1'b0, "R11 empty range");

        // Random mix on a few hashes to force collisions and evictions.
        for (int i = 0; i < 60; i++) begin
            logic [18:0] h = (i % 3 == 0) ? hA : (i % 3 == 1) ? hR : 19'($urandom);
            logic [31:0] ea = {4'($urandom), 8'($urandom), 8'($urandom), 12'($urandom)};
            logic [23:0] v = {5'($urandom), h ^ {3'b000, ea[27:12]}};
            bit rp = 1'($urandom);
            if ($urandom % 5 == 0)
                run_op(2'd2, ea, {ea[31:12], 12'h0} + 32'((1 + $urandom % 3) << 12), v, 4'($urandom), rp, "R11 random range");
            else
                run_op(2'd1, ea, 32'h0, v, 4'($urandom), rp, "R4 R7 random insert");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule